// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Modes

This block controls a parameterised bank of general-purpose pins (64 by default) through a flat 32-bit register port. Each pin owns one configuration word. The word holds the driven output level, a 3-bit operating mode, a 2-bit alternate-function select, an input-enable flag and a 3-bit interrupt-group number. The mode field carries both the plain input and output settings and the trigger type. There are no separate edge-enable or level-enable registers.

Each pin input passes through two synchronising flops. A per-pin detector then decides from the mode whether the current level or a transition is an interrupt event. Events latch into pending bits. These bits can be read as 32-pin status words, one set of words per group, and are cleared by writing ones. Each group drives one interrupt line, which is the OR of the pending bits of the pins assigned to that group.

The mode values act as the detector's states. `MODE_IN` (0) and `MODE_OUT` (1) are quiet. `MODE_LVL_HI` (2) and `MODE_LVL_LO` (3) fire on a level. `MODE_RISE` (4), `MODE_FALL` (5) and `MODE_BOTH` (6) fire on transitions. `MODE_OFF` (7) is quiet again. A pin moves between these states only through a host write to its configuration word.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The configuration word of pin p is at byte offset 4·p. Its fields are mode at bits 3:1, alternate function at bits 6:5, input enable at bit 9 and group at bits 18:16. All other bits except bit 0 read as zero. The alternate function and input enable appear on `pin_alt[2p+1:2p]` and `pin_ie[p]`.
- R2: Bit 0 written to a pin word drives `pin_out[p]`. Bit 0 read back returns the synchronised level of `pin_in[p]`, which is valid two clocks after the input changes. `pin_oe[p]` is high only in mode 1.
- R3: Mode 2 sets the pending bit while the synchronised level is 1. Mode 3 sets it while the level is 0.
- R4: Modes 4, 5 and 6 set the pending bit on a rising edge, a falling edge and either edge respectively. The bit becomes visible on the third rising clock edge after the input change.
- R5: The status word for group g and word index w (pins 32w to 32w+31) is at 0x800 + 64·g + 4·w. Bit (p mod 32) of that word shows pin p only when pin p is assigned to group g.
- R6: Writing a status word clears the pending bits written as 1. Bits written as 0 keep their value, and a pending bit stays set until it is cleared.
- R7: A clear takes priority over a same-cycle event. In a level mode with the level still active, the bit reads 0 in the cycle after the clear and sets again on the following clock.
- R8: Mode 7 raises no new pending bits. The other fields written with it are kept and read back unchanged.
- R9: `irq[g]` is high exactly when some pending pin is assigned to group g.
- R10: Reset clears all configuration fields and all pending bits. Reads of offsets that map to neither a pin word nor a status word return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | ADDR_W | Byte address of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pin_in | input | NUM_PINS | Raw pin levels |
| pin_out | output | NUM_PINS | Driven output levels |
| pin_oe | output | NUM_PINS | Output enable, high in output mode |
| pin_ie | output | NUM_PINS | Input-enable field per pin |
| pin_alt | output | 2·NUM_PINS | Alternate-function field per pin |
| irq | output | NUM_GROUPS | One interrupt line per group |

## Verification
The hardest situation to reach from the ports is the cycle just after a level-mode clear. The pending bit is low there for exactly one clock before the still-active level sets it again. The stimulus holds a level-high pin asserted, issues the clear and reads the status word in the very next cycle and again in the cycle after. The edge-mode latency is checked the same way: the status word is read in each of the four cycles after a single input transition. A write that clears through the wrong group's word shows that a status bit is reachable only through the word of its own group.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int GRP_W     = 3;
    localparam int WORD_PINS = 32;

    typedef enum logic [2:0] {
        MODE_IN     = 3'd0,
        MODE_OUT    = 3'd1,
        MODE_LVL_HI = 3'd2,
        MODE_LVL_LO = 3'd3,
        MODE_RISE   = 3'd4,
        MODE_FALL   = 3'd5,
        MODE_BOTH   = 3'd6,
        MODE_OFF    = 3'd7
    } pin_mode_e;

    typedef struct packed {
        logic [GRP_W-1:0] grp;
        logic             ie;
        logic [1:0]       alt;
        pin_mode_e        mode;
        logic             dout;
    } pin_cfg_t;

    function automatic pin_cfg_t cfg_from_word(input logic [31:0] w);
        pin_cfg_t c;
        c.dout = w[0];
        c.mode = pin_mode_e'(w[3:1]);
        c.alt  = w[6:5];
        c.ie   = w[9];
        c.grp  = w[18:16];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input pin_cfg_t c, input logic lvl);
        logic [31:0] w;
        w        = '0;
        w[0]     = lvl;
        w[3:1]   = c.mode;
        w[6:5]   = c.alt;
        w[9]     = c.ie;
        w[18:16] = c.grp;
        return w;
    endfunction

endpackage

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 64,
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_hit,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [31:0]              wr_word,
    output pin_cfg_t [NUM_PINS-1:0]  cfg
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg[p] <= '0;
            end else if (wr_hit && (wr_idx == IDX_W'(p))) begin
                cfg[p] <= cfg_from_word(wr_word);
            end
        end
    end

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_raw,
    input  pin_mode_e mode,
    output logic      lvl,
    output logic      evt
);

    logic meta;
    logic prev;
    logic rise;
    logic fall;

    // two-flop synchroniser plus one history flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= 1'b0;
            lvl  <= 1'b0;
            prev <= 1'b0;
        end else begin
            meta <= pin_raw;
            lvl  <= meta;
            prev <= lvl;
        end
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

    always_comb begin
        evt = 1'b0;
        unique case (mode)
            MODE_LVL_HI: evt = lvl;
            MODE_LVL_LO: evt = ~lvl;
            MODE_RISE:   evt = rise;
            MODE_FALL:   evt = fall;
            MODE_BOTH:   evt = rise | fall;
            MODE_IN, MODE_OUT, MODE_OFF: evt = 1'b0;
            default:     evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS   = 64,
    parameter int NUM_GROUPS = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PINS-1:0]              evt,
    input  logic [NUM_PINS-1:0]              clr,
    input  logic [NUM_PINS-1:0][GRP_W-1:0]   grp,
    output logic [NUM_PINS-1:0]              pend,
    output logic [NUM_GROUPS-1:0]            irq
);

    // clear wins over a same-cycle event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend | evt) & ~clr;
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [NUM_PINS-1:0] memb;
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_memb
            assign memb[p] = (32'(grp[p]) == g);
        end
        assign irq[g] = |(pend & memb);
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS    = 64,
    parameter int NUM_GROUPS  = 8,
    parameter int ADDR_W      = 12,
    parameter int STATUS_BASE = 'h800
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    input  logic [NUM_PINS-1:0]     pin_in,
    output logic [NUM_PINS-1:0]     pin_out,
    output logic [NUM_PINS-1:0]     pin_oe,
    output logic [NUM_PINS-1:0]     pin_ie,
    output logic [2*NUM_PINS-1:0]   pin_alt,
    output logic [NUM_GROUPS-1:0]   irq
);

    localparam int IDX_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int NUM_WORDS = (NUM_PINS + WORD_PINS - 1) / WORD_PINS;
    localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int GSEL_W    = ADDR_W - 6;

    pin_cfg_t [NUM_PINS-1:0]            cfg;
    logic [NUM_PINS-1:0][GRP_W-1:0]     grp;
    logic [NUM_PINS-1:0]                lvl;
    logic [NUM_PINS-1:0]                evt;
    logic [NUM_PINS-1:0]                pend;
    logic [NUM_PINS-1:0]                clr_vec;
    logic [NUM_WORDS*WORD_PINS-1:0]     stat_vec;

    // address decode
    logic                cfg_sel;
    logic [IDX_W-1:0]    cfg_idx;
    logic                stat_sel;
    logic [ADDR_W-1:0]   stat_off;
    logic [GSEL_W-1:0]   g_sel;
    logic [3:0]          w_sel;
    logic [WORD_W-1:0]   w_idx;

    assign cfg_sel  = (32'(addr) < NUM_PINS * 4) && (addr[1:0] == 2'b00);
    assign cfg_idx  = addr[IDX_W+1:2];
    assign stat_off = addr - ADDR_W'(STATUS_BASE);
    assign g_sel    = stat_off[ADDR_W-1:6];
    assign w_sel    = stat_off[5:2];
    assign w_idx    = w_sel[WORD_W-1:0];
    assign stat_sel = (32'(addr) >= STATUS_BASE) && (stat_off[1:0] == 2'b00) &&
                      (32'(g_sel) < NUM_GROUPS) && (32'(w_sel) < NUM_WORDS);

    gpio_cfg_bank #(.NUM_PINS(NUM_PINS)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_en && cfg_sel),
        .wr_idx  (cfg_idx),
        .wr_word (wdata),
        .cfg     (cfg)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_pin_detect det_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_raw (pin_in[p]),
            .mode    (cfg[p].mode),
            .lvl     (lvl[p]),
            .evt     (evt[p])
        );

        logic in_sel;
        assign in_sel = stat_sel && (32'(cfg[p].grp) == 32'(g_sel)) &&
                        (32'(w_sel) == p / WORD_PINS);

        assign grp[p]           = cfg[p].grp;
        assign clr_vec[p]       = wr_en && in_sel && wdata[p % WORD_PINS];
        assign stat_vec[p]      = pend[p] && in_sel;
        assign pin_out[p]       = cfg[p].dout;
        assign pin_oe[p]        = (cfg[p].mode == MODE_OUT);
        assign pin_ie[p]        = cfg[p].ie;
        assign pin_alt[2*p +: 2] = cfg[p].alt;
    end

    for (genvar p = NUM_PINS; p < NUM_WORDS * WORD_PINS; p++) begin : g_pad
        assign stat_vec[p] = 1'b0;
    end

    gpio_pend_bank #(.NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_GROUPS)) pend_i (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (clr_vec),
        .grp   (grp),
        .pend  (pend),
        .irq   (irq)
    );

    always_comb begin
        if (cfg_sel) begin
            rdata = cfg_to_word(cfg[cfg_idx], lvl[cfg_idx]);
        end else if (stat_sel) begin
            rdata = stat_vec[32'(w_idx) * WORD_PINS +: WORD_PINS];
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS   = 64,
    parameter int NUM_GROUPS = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input pin_cfg_t [NUM_PINS-1:0] cfg,
    input logic [NUM_PINS-1:0]     lvl,
    input logic [NUM_PINS-1:0]     pend,
    input logic [NUM_PINS-1:0]     clr,
    input logic [NUM_GROUPS-1:0]   irq
);

    logic [(1 << GRP_W)-1:0] irq_w;
    always_comb begin
        irq_w = '0;
        irq_w[NUM_GROUPS-1:0] = irq;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        // R6
        pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pend[p] && !clr[p] |=> pend[p]);

        // R4
        rise_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[p].mode == MODE_RISE) && lvl[p] && !$past(lvl[p]) && !clr[p] |=> pend[p]);

        // R3
        lvl_hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[p].mode == MODE_LVL_HI) && lvl[p] && !clr[p] |=> pend[p]);

        // R8
        off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg[p].mode == MODE_OFF) && !pend[p] |=> !pend[p]);

        // R9
        irq_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pend[p] && (32'(cfg[p].grp) < NUM_GROUPS) |-> irq_w[cfg[p].grp]);
    end

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
    .NUM_PINS   (NUM_PINS),
    .NUM_GROUPS (NUM_GROUPS)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg   (cfg),
    .lvl   (lvl),
    .pend  (pend),
    .clr   (clr_vec),
    .irq   (irq)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;

    localparam int NP = 64;
    localparam int NG = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe, pin_ie;
    logic [2*NP-1:0] pin_alt;
    logic [NG-1:0] irq;

    always #2 clk = ~clk;

    gpio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_ie(pin_ie), .pin_alt(pin_alt), .irq(irq)
    );

    typedef struct {
        int          kind;   // 0 rdata, 1 irq vector, 2 pad controls of pin addr
        logic [31:0] addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // monitor: compares queued expectations at the falling edge
    initial begin
        item_t it;
        logic [31:0] act;
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                it = q.pop_front();
                n_run++;
                case (it.kind)
                    0: act = rdata;
                    1: act = 32'(irq);
                    default: act = {27'b0, pin_alt[2*it.addr +: 2], pin_ie[it.addr],
                                    pin_oe[it.addr], pin_out[it.addr]};
                endcase
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int k, input logic [31:0] a, input logic [31:0] e, input string t);
        item_t it;
        it.kind = k; it.addr = a; it.exp = e; it.tag = t;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        addr = a;
        push(0, 32'(a), e, t);
    endtask

    task automatic chk_irq(input logic [31:0] e, input string t);
        push(1, 32'hFFFF_FFFF, e, t);
    endtask

    task automatic chk_pad(input int idx, input logic [31:0] e, input string t);
        push(2, 32'(idx), e, t);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R10: reset state
        rd(12'h000, 32'h0, "R10 pin0 word after reset");
        rd(12'h0FC, 32'h0, "R10 pin63 word after reset");
        rd(12'h800, 32'h0, "R10 status after reset");
        chk_irq(32'h0, "R10 irq after reset");
        chk_pad(5, 32'h0, "R10 pad controls after reset");

        // R1 R2: pin 5 output, alt 2, ie, group 3
        wr(12'h014, 32'h0003_0243);
        rd(12'h014, 32'h0003_0242, "R1 pin5 fields, level low");
        chk_pad(5, 32'h17, "R2 pin5 out/oe/ie/alt");
        pin_in[5] = 1'b1;
        idle(3);
        rd(12'h014, 32'h0003_0243, "R2 pin5 level readback");

        // R1 R8: all ones gives mode 7, only defined bits stored
        wr(12'h018, 32'hFFFF_FFFF);
        rd(12'h018, 32'h0007_026E, "R1 pin6 unused bits read zero");
        chk_pad(6, 32'h1D, "R2 pin6 oe low outside output mode");

        // R10: unmapped accesses
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h802, 32'hFFFF_FFFF);
        rd(12'h100, 32'h0, "R10 unmapped pin offset");
        rd(12'h000, 32'h0, "R10 pin0 untouched by unmapped write");
        rd(12'h802, 32'h0, "R10 misaligned status offset");
        rd(12'hA00, 32'h0, "R10 group beyond range");
        rd(12'h808, 32'h0, "R10 word beyond range");

        // R4: rising edge pin 10, group 2, latency of three edges
        wr(12'h028, 32'h0002_0008);
        pin_in[10] = 1'b1;
        rd(12'h880, 32'h0, "R4 rise latency edge0");
        rd(12'h880, 32'h0, "R4 rise latency edge1");
        rd(12'h880, 32'h0, "R4 rise latency edge2");
        rd(12'h880, 32'h0000_0400, "R4 rise pending edge3");
        chk_irq(32'h04, "R9 group2 line");
        wr(12'h800, 32'h0000_0400);
        rd(12'h880, 32'h0000_0400, "R5 clear via other group ignored");
        wr(12'h880, 32'h0);
        rd(12'h880, 32'h0000_0400, "R6 zero write keeps bit");
        wr(12'h880, 32'hFFFF_FBFF);
        rd(12'h880, 32'h0000_0400, "R6 other ones keep bit");
        wr(12'h880, 32'h0000_0400);
        rd(12'h880, 32'h0, "R6 one clears bit");
        chk_irq(32'h0, "R9 group2 line drops");
        pin_in[10] = 1'b0;
        idle(4);
        rd(12'h880, 32'h0, "R4 rise mode ignores fall");

        // R4 R5: falling edge pin 40 group 1, word 1
        wr(12'h0A0, 32'h0001_000A);
        pin_in[40] = 1'b1;
        idle(4);
        rd(12'h844, 32'h0, "R4 fall mode ignores rise");
        pin_in[40] = 1'b0;
        idle(4);
        rd(12'h844, 32'h0000_0100, "R5 pin40 in group1 word1 bit8");
        rd(12'h840, 32'h0, "R5 pin40 absent from word0");
        chk_irq(32'h02, "R9 group1 line");
        wr(12'h844, 32'h0000_0100);
        rd(12'h844, 32'h0, "R6 pin40 cleared");

        // R4: both edges pin 30 group 4
        wr(12'h078, 32'h0004_000C);
        pin_in[30] = 1'b1;
        idle(4);
        rd(12'h900, 32'h4000_0000, "R4 both mode rise");
        chk_irq(32'h10, "R9 group4 line");
        wr(12'h900, 32'h4000_0000);
        pin_in[30] = 1'b0;
        idle(4);
        rd(12'h900, 32'h4000_0000, "R4 both mode fall");
        wr(12'h900, 32'h4000_0000);

        // R3 R7: level high pin 20 group 0, alt 1, ie
        wr(12'h050, 32'h0000_0224);
        pin_in[20] = 1'b1;
        idle(4);
        rd(12'h800, 32'h0010_0000, "R3 level high pending");
        wr(12'h800, 32'h0010_0000);
        rd(12'h800, 32'h0, "R7 low in cycle after clear");
        rd(12'h800, 32'h0010_0000, "R7 set again next clock");

        // R8: disable keeps fields, no new pending
        wr(12'h050, 32'h0000_022E);
        wr(12'h800, 32'h0010_0000);
        idle(3);
        rd(12'h800, 32'h0, "R8 off mode raises nothing");
        rd(12'h050, 32'h0000_022F, "R8 fields kept in off mode");
        chk_irq(32'h0, "R9 all lines low");

        // R3: level low pin 21 group 5
        wr(12'h054, 32'h0005_0006);
        idle(1);
        rd(12'h940, 32'h0020_0000, "R3 level low pending");
        chk_irq(32'h20, "R9 group5 line");
        pin_in[21] = 1'b1;
        idle(3);
        wr(12'h940, 32'h0020_0000);
        idle(1);
        rd(12'h940, 32'h0, "R3 level low stays clear when high");

        // R10: reset in mid-run
        pin_in = '0;
        idle(3);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        rd(12'h014, 32'h0, "R10 pin5 word after second reset");
        rd(12'h050, 32'h0, "R10 pin20 word after second reset");
        chk_irq(32'h0, "R10 irq after second reset");

        idle(2);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule